// File: doc/BRIEF.md
# Floating-Point Register Stack

An eight-deep file of 80-bit floating-point registers whose entries are named relative to a moving top pointer. ST(0) is the top entry and ST(i) is the entry i places below it. A push puts a new value on top and renumbers every older entry one place deeper. A pop discards the top and renumbers every entry one place shallower. No data moves between storage cells: only a 3-bit top pointer changes, and each name maps to physical cell (top + i) mod 8.

An external arithmetic unit reads two combinational ports. One port always shows ST(0). The other shows the non-top operand of the current request. The unit then returns its result through a write command, which may target ST(0) or ST(i) and may pop afterward. The block also supports:
- store with pop and store without pop, where the stored value is read on the ST(0) port;
- exchange of ST(0) with ST(i);
- an initialize command.

Each physical cell carries a valid tag. Overflow, underflow and illegal-operand conditions each produce a one-cycle flag. A rejected request leaves the stack state unchanged.

Top module: `fp_reg_stack`

## Requirements
- R1: After reset, and in the cycle after an initialize command (op_i = 1), every entry is empty: st0_vld_o is low and a following store (op_i = 4) reports underflow.
- R2: A push (op_i = 2) with fewer than eight valid entries places ld_data_i in ST(0), and each previous ST(i) becomes ST(i+1).
- R3: A push while all eight entries are valid raises ovf_o for exactly the following cycle and leaves every entry and the top unchanged.
- R4: A store-and-pop (op_i = 3) with ST(0) valid removes ST(0), and each ST(i) becomes ST(i-1) for i = 1..7.
- R5: A store without pop (op_i = 4) leaves every entry and its valid state unchanged.
- R6: Any request that reads an empty operand raises unf_o for the following cycle and changes no state. The operands are: ST(0) for store and pop; ST(0) and ST(dst_i) for exchange and write-pop; ST(0) and the non-top operand for write.
- R7: An exchange (op_i = 5) swaps the contents of ST(0) and ST(dst_i) in one cycle.
- R8: A write (op_i = 6) with src_i = 0, or with dst_i = 0, stores res_data_i into ST(dst_i) and does not move the top.
- R9: A write with both dst_i and src_i nonzero, or a write-pop with src_i nonzero, raises opnd_err_o for the following cycle and changes no state.
- R10: A write-pop (op_i = 7) with src_i = 0 stores res_data_i into ST(dst_i) and then pops. For example, a write-pop to ST(2) leaves the result in the new ST(1).
- R11: st0_o and st0_vld_o show ST(0). sti_o and sti_vld_o show ST(dst_i) when dst_i is nonzero, and ST(src_i) otherwise.
- R12: At most one of ovf_o, unf_o and opnd_err_o is high in any cycle, and no flag rises for a no-op (op_i = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Command: 0 nop, 1 init, 2 push, 3 store-pop, 4 store, 5 exchange, 6 write, 7 write-pop |
| dst_i | input | 3 | Relative index i of the destination or exchange partner |
| src_i | input | 3 | Relative index of the second operand of a write |
| ld_data_i | input | 80 | Value pushed by a push |
| res_data_i | input | 80 | Arithmetic result written by write or write-pop |
| st0_o | output | 80 | Contents of ST(0) |
| sti_o | output | 80 | Contents of the selected non-top operand |
| st0_vld_o | output | 1 | ST(0) holds a valid value |
| sti_vld_o | output | 1 | The selected operand holds a valid value |
| ovf_o | output | 1 | Previous command overflowed the stack |
| unf_o | output | 1 | Previous command read an empty entry |
| opnd_err_o | output | 1 | Previous command named an illegal operand pair |

## Verification
The assertions assume that op_i, dst_i, src_i and both data inputs are settled before each rising edge, and that they come from the eight listed command codes. Under that assumption the error flags can be tied to the command of the previous cycle. The bench drives every input on the falling edge and draws commands from all eight codes. It biases the draws so that the depth wanders between empty and full, and it mostly keeps one operand index at zero, so that legal two-operand writes outnumber rejected ones.

// File: rtl/fp_reg_stack.sv
module fp_reg_stack #(
  parameter int W = 80,
  parameter int D = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           op_i,
  input  logic [$clog2(D)-1:0] dst_i,
  input  logic [$clog2(D)-1:0] src_i,
  input  logic [W-1:0]         ld_data_i,
  input  logic [W-1:0]         res_data_i,
  output logic [W-1:0]         st0_o,
  output logic [W-1:0]         sti_o,
  output logic                 st0_vld_o,
  output logic                 sti_vld_o,
  output logic                 ovf_o,
  output logic                 unf_o,
  output logic                 opnd_err_o
);
  localparam int AW = $clog2(D);
  localparam logic [2:0] OP_NOP = 3'd0, OP_INIT = 3'd1, OP_PUSH = 3'd2, OP_POP = 3'd3,
                         OP_STORE = 3'd4, OP_XCHG = 3'd5, OP_WR = 3'd6, OP_WRPOP = 3'd7;

  logic [W-1:0]  mem [D];
  logic [D-1:0]  tag;
  logic [AW-1:0] top;
  logic          ovf, unf, opr, ok;

  wire [AW-1:0] sel = (dst_i != '0) ? dst_i : src_i;
  wire [AW-1:0] p0  = top;
  wire [AW-1:0] pd  = top + dst_i;
  wire [AW-1:0] ps  = top + sel;
  wire [AW-1:0] pn  = top - 1'b1;
  wire [AW-1:0] pu  = top + 1'b1;

  assign st0_o     = mem[p0];
  assign sti_o     = mem[ps];
  assign st0_vld_o = tag[p0];
  assign sti_vld_o = tag[ps];

  always_comb begin
    ovf = 1'b0;
    unf = 1'b0;
    opr = 1'b0;
    case (op_i)
      OP_PUSH:          ovf = tag[pn];
      OP_POP, OP_STORE: unf = !tag[p0];
      OP_XCHG:          unf = !tag[p0] || !tag[pd];
      OP_WR:
        if (dst_i != '0 && src_i != '0) opr = 1'b1;
        else                            unf = !tag[p0] || !tag[ps];
      OP_WRPOP:
        if (src_i != '0) opr = 1'b1;
        else             unf = !tag[p0] || !tag[pd];
      default: ;
    endcase
  end
  assign ok = !(ovf || unf || opr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top <= '0;
      tag <= '0;
      {ovf_o, unf_o, opnd_err_o} <= 3'b000;
    end else begin
      {ovf_o, unf_o, opnd_err_o} <= {ovf, unf, opr};
      if (ok) begin
        case (op_i)
          OP_INIT: begin top <= '0; tag <= '0; end
          OP_PUSH: begin top <= pn; tag[pn] <= 1'b1; end
          OP_POP, OP_WRPOP: begin top <= pu; tag[p0] <= 1'b0; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ok) begin
      case (op_i)
        OP_PUSH:  mem[pn] <= ld_data_i;
        OP_XCHG:  begin mem[p0] <= mem[pd]; mem[pd] <= mem[p0]; end
        OP_WR:    mem[ps] <= (dst_i != '0) ? res_data_i : mem[ps];
        default: ;
      endcase
      if (op_i == OP_WRPOP || (op_i == OP_WR && dst_i == '0)) mem[pd] <= res_data_i;
    end
  end

  assert_init_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == OP_INIT |=> !st0_vld_o && tag == '0);
  assert_overflow_only_on_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> $past(op_i) == OP_PUSH);
  assert_push_lands_on_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_PUSH && ok) |=> st0_vld_o && st0_o == $past(ld_data_i));
  assert_error_keeps_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o || unf_o || opnd_err_o) |-> $stable(top) && $stable(tag));
  assert_errors_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_o, unf_o, opnd_err_o}));
  assert_nop_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == OP_NOP |=> !ovf_o && !unf_o && !opnd_err_o);
endmodule

// File: tb/test_fp_reg_stack.sv
module test_fp_reg_stack;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = 3'd0, dst_i = 3'd0, src_i = 3'd0;
  logic [79:0] ld_data_i = '0, res_data_i = '0;
  logic [79:0] st0_o, sti_o;
  logic        st0_vld_o, sti_vld_o, ovf_o, unf_o, opnd_err_o;

  int checks = 0, fails = 0;
  logic [79:0] m [8];
  int n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_reg_stack i_fp_reg_stack (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .dst_i(dst_i), .src_i(src_i),
    .ld_data_i(ld_data_i), .res_data_i(res_data_i), .st0_o(st0_o), .sti_o(sti_o),
    .st0_vld_o(st0_vld_o), .sti_vld_o(sti_vld_o), .ovf_o(ovf_o), .unf_o(unf_o),
    .opnd_err_o(opnd_err_o));

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_err(input logic [2:0] op, input int d, input int s);
    int sel = (d != 0) ? d : s;
    case (op)
      3'd2: return {n == 8, 2'b00};
      3'd3, 3'd4: return {1'b0, n == 0, 1'b0};
      3'd5: return {1'b0, (n == 0) || (d >= n), 1'b0};
      3'd6: if (d != 0 && s != 0) return 3'b001;
            else return {1'b0, (n == 0) || (sel >= n), 1'b0};
      3'd7: if (s != 0) return 3'b001;
            else return {1'b0, (n == 0) || (d >= n), 1'b0};
      default: return 3'b000;
    endcase
  endfunction

  task automatic model_apply(input logic [2:0] op, input int d, input int s,
                             input logic [79:0] ld, input logic [79:0] res);
    logic [79:0] t;
    case (op)
      3'd1: n = 0;
      3'd2: begin
        for (int i = 7; i > 0; i--) m[i] = m[i-1];
        m[0] = ld; n++;
      end
      3'd3: begin
        for (int i = 0; i < 7; i++) m[i] = m[i+1];
        n--;
      end
      3'd5: begin t = m[0]; m[0] = m[d]; m[d] = t; end
      3'd6: m[(d != 0) ? d : 0] = res;
      3'd7: begin
        m[d] = res;
        for (int i = 0; i < 7; i++) m[i] = m[i+1];
        n--;
      end
      default: ;
    endcase
  endtask

  task automatic do_op(input logic [2:0] op, input int d, input int s,
                       input logic [79:0] ld, input logic [79:0] res);
    logic [2:0] e;
    int sel;
    op_i = op; dst_i = 3'(d); src_i = 3'(s); ld_data_i = ld; res_data_i = res;
    #1;
    sel = (d != 0) ? d : s;
    chk("R11 st0 valid", 80'(st0_vld_o), 80'(n > 0));
    if (n > 0) chk("R11 st0 data (R2 R4 R7 R8 R10)", st0_o, m[0]);
    chk("R11 sti valid", 80'(sti_vld_o), 80'(sel < n));
    if (sel < n) chk("R11 sti data (R2 R4 R5 R7 R8 R10)", sti_o, m[sel]);
    e = exp_err(op, d, s);
    if (e == 3'b000) model_apply(op, d, s, ld, res);
    @(posedge clk);
    @(negedge clk);
    chk("R3 R6 R9 R12 error flags", 80'({ovf_o, unf_o, opnd_err_o}), 80'(e));
    op_i = 3'd0;
  endtask

  function automatic logic [79:0] rnd80();
    return {$urandom(), $urandom(), 16'($urandom())};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset empty", 80'(st0_vld_o), 80'd0);
    chk("R12 reset flags", 80'({ovf_o, unf_o, opnd_err_o}), 80'd0);
    do_op(3'd4, 0, 0, '0, '0);                       // R1 store on empty underflows
    for (int k = 0; k < 8; k++) do_op(3'd2, 0, 0, 80'(k + 100), '0);  // R2
    do_op(3'd2, 0, 0, 80'hDEAD, '0);                 // R3 overflow
    do_op(3'd4, 3, 0, '0, '0);                       // R5 store keeps state
    do_op(3'd5, 5, 0, '0, '0);                       // R7 exchange
    do_op(3'd6, 2, 4, '0, 80'h1);                    // R9 two non-top
    do_op(3'd7, 2, 1, '0, 80'h2);                    // R9 write-pop src
    do_op(3'd6, 0, 3, '0, 80'h33);                   // R8 to ST(0)
    do_op(3'd6, 6, 0, '0, 80'h66);                   // R8 to ST(6)
    do_op(3'd7, 2, 0, '0, 80'h77);                   // R10
    chk("R10 result now ST(1)", m[1], 80'h77);
    do_op(3'd0, 1, 0, '0, '0);
    do_op(3'd3, 0, 0, '0, '0);                       // R4
    do_op(3'd1, 0, 0, '0, '0);                       // R1 init
    do_op(3'd4, 0, 0, '0, '0);                       // R1 underflow after init
    do_op(3'd3, 0, 0, '0, '0);                       // R6
    do_op(3'd2, 0, 0, 80'h5, '0);
    do_op(3'd5, 3, 0, '0, '0);                       // R6 exchange with empty
    for (int k = 0; k < 4000; k++) begin
      logic [2:0] op;
      int d, s, r;
      r = int'($urandom() % 16);
      if (r < 5) op = 3'd2;
      else if (r < 7) op = 3'd3;
      else if (r == 15 && ($urandom() % 8) == 0) op = 3'd1;
      else op = 3'(r % 8);
      d = int'($urandom() % 8);
      s = (($urandom() % 4) == 0) ? int'($urandom() % 8) : 0;
      if (op == 3'd6 && ($urandom() % 2) == 0) begin s = d; d = 0; end
      do_op(op, d, s, rnd80(), rnd80());
    end
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule